// File: doc/BRIEF.md
# Indirect PHY Control-Register Access Master

This block lets on-chip logic read and write the internal control registers of a serial PHY that are reachable only through a paged window on a 32-bit memory-mapped port. A caller hands over one command: a read or write flag, a 5-bit device number, a 16-bit PHY register address and, for writes, 16-bit data. The block then runs a fixed handshake with the PHY's control interface and reports completion with a one-cycle done pulse. A read also returns its data with that pulse.

The PHY's control interface has three registers: control, address and data. Every access to one of them is itself two bus transactions. The first writes a page word that selects the device and the upper address bits. The second is the actual read or write inside the window. The block first waits until the control register reports idle. Busy polls are spaced by a configurable idle gap, which is about 5 µs at the default parameters. The number of busy polls in one wait phase is capped. When the cap is hit, the command ends with a timeout flag and the block makes no further bus requests.

Only one command is in flight at a time. The ready output is low from acceptance until the final bus access has been acknowledged.

Top module: `sdsCtlMaster`

## Requirements
- R1: After reset, cmdReady is 1, while busReq, rspDone and rspTimeout are 0.
- R2: Every register access is a page-word write to bus byte offset 0x800 followed directly by the windowed access at offset regAddr[8:0]*4. The page word is (device << 7) | regAddr[15:9]. The PHY registers are control 0x80A0, address 0x80A1 and data 0x80A2, which gives window offsets 0x280, 0x284 and 0x288 and page word (device << 7) | 0x40.
- R3: A read runs five steps in order. It polls control until bit 0 (busy) reads 0. It writes the command address to the address register. It writes control = 0x0001 (start). It polls busy again. It then reads the data register. rspData carries bits [15:0] of that read when rspDone pulses.
- R4: A write runs four steps in order. It polls control until busy is clear. It writes the address register, then the data register. It then writes control = 0x0003 (start plus bit 1, write select). It finishes without polling afterwards, and no bus request follows its done pulse.
- R5: Consecutive busy polls are separated by exactly POLL_GAP cycles with busReq low. No idle cycles appear anywhere else inside a command.
- R6: If POLL_LIMIT consecutive polls in one wait phase all read busy, the command ends with rspDone and rspTimeout both 1. It makes no further bus requests, and a write that times out never writes its start word.
- R7: While a command is in progress, cmdReady is 0 and cmdValid is ignored.
- R8: rspDone lasts one cycle. cmdReady returns high in that same cycle, so the next command can be accepted on the edge that ends it.
- R9: busReq, busAddr, busWe and busWdata hold steady until the cycle in which busAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle; a command is taken when valid and ready are both high |
| cmdWrite | input | 1 | 1 = write command, 0 = read command |
| cmdDev | input | 5 | PHY device number |
| cmdAddr | input | 16 | PHY internal register address |
| cmdWdata | input | 16 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspTimeout | output | 1 | Command ended on the poll limit; valid with rspDone |
| rspData | output | 16 | Read result; valid with rspDone for a read without timeout |
| busReq | output | 1 | Bus request |
| busWe | output | 1 | Bus write enable |
| busAddr | output | 12 | Bus byte offset |
| busWdata | output | 32 | Bus write data |
| busAck | input | 1 | Bus acknowledge, one cycle |
| busRdata | input | 32 | Bus read data, valid with busAck |

## Verification
Two events can fall in the same cycle: the done pulse of one command and the acceptance of the next. The bench provokes this by holding cmdValid high with a second command while the first is still running. In the cycle that rspDone shows, it checks that cmdReady is already high and that the first result is correct. It then checks that the second command was taken on that edge and completes with its own effect on the PHY model. A second overlap is a command offered while one is busy. The bench judges it by the bus transaction count and by the absence of any further activity after the done pulse.

// File: rtl/sdsCtlPkg.sv
package sdsCtlPkg;
  localparam int REG_W = 16;

  // PHY control-interface registers reached through the window
  localparam logic [REG_W-1:0] REG_CTL = 16'h80A0;
  localparam logic [REG_W-1:0] REG_ADR = 16'h80A1;
  localparam logic [REG_W-1:0] REG_DAT = 16'h80A2;

  localparam int CTL_GO_BIT = 0;  // read: busy, write: start
  localparam int CTL_WR_BIT = 1;  // 1 = write, 0 = read

  typedef enum logic [2:0] {
    SP_POLL_PRE,
    SP_ADDR,
    SP_DATA,
    SP_START,
    SP_POLL_POST,
    SP_FETCH
  } stepT;

  typedef struct packed {
    logic load;      // latch a new command
    logic capture;   // store read data
    logic winPhase;  // 0: page write, 1: windowed access
    stepT step;      // which register access is running
  } strobeT;
endpackage

// File: rtl/sdsCtlPath.sv
module sdsCtlPath
  import sdsCtlPkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int BUS_AW = 12,
  parameter int BUS_DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              cmdWrite,
  input  logic [DEV_W-1:0]  cmdDev,
  input  logic [REG_W-1:0]  cmdAddr,
  input  logic [REG_W-1:0]  cmdWdata,
  input  logic [BUS_DW-1:0] busRdata,
  output logic [BUS_AW-1:0] busAddr,
  output logic              busWe,
  output logic [BUS_DW-1:0] busWdata,
  output logic              busyBit,
  output logic              isWrite,
  output logic [REG_W-1:0]  rspData
);
  localparam int IDX_W = BUS_AW - 3;
  localparam logic [BUS_AW-1:0] PAGE_OFF = {1'b1, {(BUS_AW-1){1'b0}}};

  logic [DEV_W-1:0] devQ;
  logic [REG_W-1:0] addrQ;
  logic [REG_W-1:0] dataQ;
  logic [REG_W-1:0] regSel;
  logic [REG_W-1:0] startWord;
  logic [REG_W-1:0] winData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devQ    <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
      isWrite <= 1'b0;
      rspData <= '0;
    end else begin
      if (strobe.load) begin
        devQ    <= cmdDev;
        addrQ   <= cmdAddr;
        dataQ   <= cmdWdata;
        isWrite <= cmdWrite;
      end
      if (strobe.capture) rspData <= busRdata[REG_W-1:0];
    end
  end

  always_comb begin
    case (strobe.step)
      SP_ADDR:            regSel = REG_ADR;
      SP_DATA, SP_FETCH:  regSel = REG_DAT;
      default:            regSel = REG_CTL;
    endcase
  end

  always_comb begin
    startWord             = '0;
    startWord[CTL_GO_BIT] = 1'b1;
    startWord[CTL_WR_BIT] = isWrite;
    case (strobe.step)
      SP_ADDR:  winData = addrQ;
      SP_DATA:  winData = dataQ;
      SP_START: winData = startWord;
      default:  winData = '0;
    endcase
  end

  always_comb begin
    if (strobe.winPhase) begin
      busAddr  = {1'b0, regSel[IDX_W-1:0], 2'b00};
      busWe    = (strobe.step == SP_ADDR) || (strobe.step == SP_DATA) ||
                 (strobe.step == SP_START);
      busWdata = BUS_DW'(winData);
    end else begin
      busAddr  = PAGE_OFF;
      busWe    = 1'b1;
      busWdata = BUS_DW'({devQ, regSel[REG_W-1:IDX_W]});
    end
  end

  assign busyBit = busRdata[CTL_GO_BIT];
endmodule

// File: rtl/sdsCtlFsm.sv
module sdsCtlFsm
  import sdsCtlPkg::*;
#(
  parameter int POLL_GAP   = 625,
  parameter int POLL_LIMIT = 1000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdValid,
  input  logic   busAck,
  input  logic   busyBit,
  input  logic   isWrite,
  output logic   cmdReady,
  output logic   busReq,
  output strobeT strobe,
  output logic   rspDone,
  output logic   rspTimeout
);
  localparam int PC_W = $clog2(POLL_LIMIT + 1);
  localparam int GC_W = $clog2(POLL_GAP + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(POLL_LIMIT - 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'(POLL_GAP - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PAGE, ST_WIN, ST_WAIT} stateT;

  stateT           state;
  stepT            step;
  logic [PC_W-1:0] pollCnt;
  logic [GC_W-1:0] gapCnt;
  logic            isPoll;

  assign isPoll = (step == SP_POLL_PRE) || (step == SP_POLL_POST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      step       <= SP_POLL_PRE;
      pollCnt    <= '0;
      gapCnt     <= '0;
      rspDone    <= 1'b0;
      rspTimeout <= 1'b0;
    end else begin
      rspDone <= 1'b0;
      case (state)
        ST_IDLE: if (cmdValid) begin
          state      <= ST_PAGE;
          step       <= SP_POLL_PRE;
          pollCnt    <= '0;
          rspTimeout <= 1'b0;
        end
        ST_PAGE: if (busAck) state <= ST_WIN;
        ST_WIN: if (busAck) begin
          if (isPoll && busyBit) begin
            if (pollCnt == PC_LAST) begin
              state      <= ST_IDLE;
              rspDone    <= 1'b1;
              rspTimeout <= 1'b1;
            end else begin
              pollCnt <= pollCnt + 1'b1;
              gapCnt  <= '0;
              state   <= ST_WAIT;
            end
          end else begin
            state <= ST_PAGE;
            case (step)
              SP_POLL_PRE: begin
                pollCnt <= '0;
                step    <= SP_ADDR;
              end
              SP_ADDR:  step <= isWrite ? SP_DATA : SP_START;
              SP_DATA:  step <= SP_START;
              SP_START: begin
                if (isWrite) begin
                  state   <= ST_IDLE;
                  rspDone <= 1'b1;
                end else begin
                  step <= SP_POLL_POST;
                end
              end
              SP_POLL_POST: begin
                pollCnt <= '0;
                step    <= SP_FETCH;
              end
              default: begin
                state   <= ST_IDLE;
                rspDone <= 1'b1;
              end
            endcase
          end
        end
        default: begin
          if (gapCnt == GC_LAST) state <= ST_PAGE;
          else gapCnt <= gapCnt + 1'b1;
        end
      endcase
    end
  end

  assign cmdReady        = (state == ST_IDLE);
  assign busReq          = (state == ST_PAGE) || (state == ST_WIN);
  assign strobe.load     = cmdReady && cmdValid;
  assign strobe.capture  = (state == ST_WIN) && busAck && (step == SP_FETCH);
  assign strobe.winPhase = (state == ST_WIN);
  assign strobe.step     = step;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R3: every completion is caused by an acknowledged bus access
  a_r3_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> $past(busAck));

  // R6: a timeout is only reported right after a busy read
  a_r6_timeout_on_busy: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && rspTimeout) |-> $past(busyBit));
endmodule

// File: rtl/sdsCtlMaster.sv
module sdsCtlMaster
  import sdsCtlPkg::*;
#(
  parameter int DEV_W      = 5,
  parameter int BUS_AW     = 12,
  parameter int BUS_DW     = 32,
  parameter int POLL_GAP   = 625,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [DEV_W-1:0]  cmdDev,
  input  logic [15:0]       cmdAddr,
  input  logic [15:0]       cmdWdata,
  output logic              rspDone,
  output logic              rspTimeout,
  output logic [15:0]       rspData,
  output logic              busReq,
  output logic              busWe,
  output logic [BUS_AW-1:0] busAddr,
  output logic [BUS_DW-1:0] busWdata,
  input  logic              busAck,
  input  logic [BUS_DW-1:0] busRdata
);
  localparam logic [BUS_AW-1:0] PAGE_OFF = {1'b1, {(BUS_AW-1){1'b0}}};

  strobeT strobe;
  logic   busyBit;
  logic   isWrite;

  sdsCtlFsm #(
    .POLL_GAP  (POLL_GAP),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .busAck    (busAck),
    .busyBit   (busyBit),
    .isWrite   (isWrite),
    .cmdReady  (cmdReady),
    .busReq    (busReq),
    .strobe    (strobe),
    .rspDone   (rspDone),
    .rspTimeout(rspTimeout)
  );

  sdsCtlPath #(
    .DEV_W (DEV_W),
    .BUS_AW(BUS_AW),
    .BUS_DW(BUS_DW)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdWrite(cmdWrite),
    .cmdDev  (cmdDev),
    .cmdAddr (cmdAddr),
    .cmdWdata(cmdWdata),
    .busRdata(busRdata),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busWdata(busWdata),
    .busyBit (busyBit),
    .isWrite (isWrite),
    .rspData (rspData)
  );

  // R9: request and its payload hold until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWe) &&
                             $stable(busWdata)));

  // R2: an acknowledged page write is followed at once by a window access
  a_r2_window_after_page: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && busAddr == PAGE_OFF) |=> (busReq && busAddr != PAGE_OFF));
endmodule

// File: tb/sdsCtlMaster_bench.sv
module sdsCtlMaster_bench;
  localparam int GAP   = 4;
  localparam int LIMIT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [4:0]  cmdDev = '0;
  logic [15:0] cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic        cmdReady, rspDone, rspTimeout, busReq, busWe;
  logic [15:0] rspData;
  logic [11:0] busAddr;
  logic [31:0] busWdata;
  logic        busAck;
  logic [31:0] busRdata;

  always #4 clk = ~clk;  // 125 MHz

  sdsCtlMaster #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) u_sdsCtlMaster (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdDev(cmdDev), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .rspDone(rspDone), .rspTimeout(rspTimeout), .rspData(rspData),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [15:0] phyVal(input logic [4:0] d, input logic [15:0] a);
    return {d, 11'h000} ^ a ^ 16'h5A3C;
  endfunction

  // PHY model configuration, driven only by the stimulus process
  int         cfgBusyPre = 0;
  int         cfgBusyPost = 0;
  logic [4:0] cfgDev = '0;

  // PHY model state
  int          busyLeft, txCount, pageErr, orderErr, writesDone;
  logic [11:0] pageW;
  logic        pageFresh;
  logic [15:0] addrReg, dataReg, readLatched, startVal;
  logic [4:0]  lastWrDev;
  logic [15:0] lastWrAddr, lastWrData;

  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0; busRdata <= '0; busyLeft <= 0; txCount <= 0;
      pageErr <= 0; orderErr <= 0; writesDone <= 0; pageW <= '0;
      pageFresh <= 1'b0; addrReg <= '0; dataReg <= '0; readLatched <= '0;
      startVal <= '0; lastWrDev <= '0; lastWrAddr <= '0; lastWrData <= '0;
    end else begin
      if (cmdValid && cmdReady) busyLeft <= cfgBusyPre;
      if (busReq && !busAck) begin
        busAck   <= 1'b1;
        busRdata <= 32'hFFFF_0000;
        txCount  <= txCount + 1;
        if (busAddr == 12'h800) begin
          if (!busWe) orderErr <= orderErr + 1;
          if (busWdata != {20'h0, cfgDev, 7'h40}) pageErr <= pageErr + 1;
          pageW     <= busWdata[11:0];
          pageFresh <= 1'b1;
        end else begin
          pageFresh <= 1'b0;
          if (!pageFresh || busAddr[11] || busAddr[1:0] != 2'b00) orderErr <= orderErr + 1;
          case ({pageW[6:0], busAddr[10:2]})
            16'h80A0: begin
              if (!busWe) begin
                busRdata <= {16'hC3C2, 15'h0, busyLeft > 0};
                if (busyLeft > 0) busyLeft <= busyLeft - 1;
              end else begin
                startVal <= busWdata[15:0];
                if (busWdata[0] && busWdata[1]) begin
                  writesDone <= writesDone + 1;
                  lastWrDev  <= pageW[11:7];
                  lastWrAddr <= addrReg;
                  lastWrData <= dataReg;
                end else if (busWdata[0]) begin
                  readLatched <= phyVal(pageW[11:7], addrReg);
                end
                busyLeft <= cfgBusyPost;
              end
            end
            16'h80A1: if (busWe) addrReg <= busWdata[15:0]; else orderErr <= orderErr + 1;
            16'h80A2: begin
              if (busWe) dataReg <= busWdata[15:0];
              else busRdata <= {16'hBEEF, readLatched};
            end
            default: orderErr <= orderErr + 1;
          endcase
        end
      end else begin
        busAck <= 1'b0;
      end
    end
  end

  // longest run of request-low cycles while a command is busy (R5)
  int run = 0;
  int maxRun = 0;
  always @(negedge clk) begin
    if (!cmdReady && !busReq) begin
      run = run + 1;
      if (run > maxRun) maxRun = run;
    end else run = 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [4:0] d, input logic [15:0] a,
                       input logic [15:0] w);
    @(negedge clk);
    cmdWrite = wr; cmdDev = d; cmdAddr = a; cmdWdata = w; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone();
    while (!rspDone) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [4:0]  dev;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [3:0]  pre;
    logic [3:0]  post;
  } vecT;

  localparam vecT VEC [8] = '{
    '{1'b0, 5'h03, 16'h1234, 16'h0000, 4'd0, 4'd0},
    '{1'b1, 5'h1F, 16'hFFFF, 16'hA5C3, 4'd1, 4'd0},
    '{1'b0, 5'h00, 16'h0000, 16'h0000, 4'd2, 4'd2},
    '{1'b1, 5'h07, 16'h8001, 16'h0001, 4'd0, 4'd0},
    '{1'b0, 5'h10, 16'hABCD, 16'h0000, 4'd3, 4'd0},
    '{1'b0, 5'h09, 16'h0200, 16'h0000, 4'd0, 4'd3},
    '{1'b1, 5'h02, 16'h4321, 16'h7777, 4'd3, 4'd0},
    '{1'b0, 5'h15, 16'h7E00, 16'h0000, 4'd1, 4'd1}
  };

  initial begin
    repeat (120000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", cmdReady, 1);
    chk("R1 no request after reset", busReq, 0);
    chk("R1 no done after reset", rspDone, 0);
    chk("R1 no timeout after reset", rspTimeout, 0);

    for (int i = 0; i < 8; i++) begin
      automatic vecT v = VEC[i];
      automatic int pre = int'(v.pre);
      automatic int post = int'(v.post);
      automatic bit toPre = pre >= LIMIT;
      automatic bit toPost = !v.wr && !toPre && post >= LIMIT;
      automatic bit expTo = toPre || toPost;
      automatic int expTx;
      automatic int expRun;
      automatic int tx0, wd0, tx1;
      if (toPre) expTx = 2 * LIMIT;
      else if (toPost) expTx = 2 * (pre + 1) + 4 + 2 * LIMIT;
      else if (v.wr) expTx = 2 * pre + 8;
      else expTx = 2 * (pre + post) + 10;
      expRun = (pre > 0 || (!v.wr && !toPre && post > 0)) ? GAP : 0;
      cfgBusyPre = pre; cfgBusyPost = post; cfgDev = v.dev;
      tx0 = txCount; wd0 = writesDone; maxRun = 0;
      issue(v.wr, v.dev, v.addr, v.wdata);
      waitDone();
      chk($sformatf("R6 timeout flag vec%0d", i), rspTimeout, expTo);
      chk($sformatf("R2 R3 R4 transaction count vec%0d", i), txCount - tx0, expTx);
      chk($sformatf("R5 poll gap vec%0d", i), maxRun, expRun);
      chk($sformatf("R2 page word vec%0d", i), pageErr, 0);
      chk($sformatf("R2 page-then-window order vec%0d", i), orderErr, 0);
      if (!expTo && !v.wr) begin
        chk($sformatf("R3 read data vec%0d", i), rspData, phyVal(v.dev, v.addr));
        chk($sformatf("R3 start word vec%0d", i), startVal, 16'h0001);
      end
      if (v.wr) begin
        chk($sformatf("R4 R6 write effect count vec%0d", i), writesDone - wd0, expTo ? 0 : 1);
        if (!expTo) begin
          chk($sformatf("R4 start word vec%0d", i), startVal, 16'h0003);
          chk($sformatf("R4 written fields vec%0d", i), {11'h0, lastWrDev, lastWrAddr},
              {11'h0, v.dev, v.addr});
          chk($sformatf("R4 written data vec%0d", i), lastWrData, v.wdata);
        end
      end
      tx1 = txCount;
      @(negedge clk);
      chk($sformatf("R8 done is one cycle vec%0d", i), rspDone, 0);
      repeat (6) @(negedge clk);
      chk($sformatf("R4 R6 quiet after done vec%0d", i), txCount - tx1, 0);
    end

    // R7: a command offered while busy is ignored
    begin
      automatic int tx0;
      cfgBusyPre = 1; cfgBusyPost = 0; cfgDev = 5'h06;
      tx0 = txCount;
      issue(1'b0, 5'h06, 16'h3C3C, 16'h0000);
      repeat (2) @(negedge clk);
      chk("R7 ready low while busy", cmdReady, 0);
      cmdWrite = 1'b1; cmdAddr = 16'h9999; cmdWdata = 16'h1111; cmdValid = 1'b1;
      repeat (2) @(negedge clk);
      cmdValid = 1'b0;
      waitDone();
      chk("R7 first result intact", rspData, phyVal(5'h06, 16'h3C3C));
      repeat (8) @(negedge clk);
      chk("R7 no second command ran", txCount - tx0, 12);
      chk("R7 ready after ignored offer", cmdReady, 1);
    end

    // R8: done of one command and acceptance of the next share a cycle
    begin
      automatic int wd0 = writesDone;
      cfgBusyPre = 0; cfgBusyPost = 1; cfgDev = 5'h04;
      @(negedge clk);
      cmdWrite = 1'b0; cmdDev = 5'h04; cmdAddr = 16'h0F0F; cmdValid = 1'b1;
      @(negedge clk);
      cmdWrite = 1'b1; cmdAddr = 16'h1111; cmdWdata = 16'h2222;
      waitDone();
      chk("R8 ready in done cycle", cmdReady, 1);
      chk("R8 first read data", rspData, phyVal(5'h04, 16'h0F0F));
      @(negedge clk);
      cmdValid = 1'b0;
      chk("R8 next command taken at done edge", cmdReady, 0);
      waitDone();
      chk("R8 second command no timeout", rspTimeout, 0);
      chk("R8 second command wrote", writesDone - wd0, 1);
      chk("R8 second write data", lastWrData, 16'h2222);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule